// File: doc/BRIEF.md
# Activity-Gated Registered Eight-Way Selector

This block picks one of eight byte-wide data lanes and presents it on a registered output. Each lane is held in its own input register, and the lane code passes through two register stages before it steers the output multiplexer. The block is built so that input registers switch as little as possible. A lane register loads only on the edge just before the output stage reads it, and the other seven keep their old contents. The output sequence is identical, cycle for cycle, to a plain pipeline in which every lane register loads on every edge.

A build parameter switches the gating off, which gives the always-loading reference pipeline. Gating is also left off when the lanes are narrower than a configurable minimum width (eight bits by default). A saturating activity counter for each lane register counts the bits that register flips. This lets the gated and ungated builds be compared on switching activity as well as on function.

Top module: `actgate_sel8`

## Requirements
- R1: While `rst_n` is low, `dout` is zero and every activity counter in `act_cnt` is zero.
- R2: Call the edge that loads `dout` edge n. `dout` then equals lane `sel` of the `din` value sampled at edge n-1, where `sel` is the value sampled at edge n-2 (two select stages, one data stage, one output stage).
- R3: Lane code k (0 to 7) selects lane k. Lane k occupies bits `din[8k+7:8k]`, and its counter occupies `act_cnt[16k+15:16k]`.
- R4: When gating is active, lane register k loads only on an edge at which the first select stage holds code k. On every other edge it holds its value, so its activity counter does not change.
- R5: A gated build and an ungated build driven with the same inputs produce the same `dout` on every cycle.
- R6: On each edge, a lane's activity counter grows by the number of bits that change in that lane register. It never decreases and saturates at all ones.
- R7: Under random data and lane codes, the summed activity of all lanes in the gated build is lower than in the ungated build.
- R8: With `GATE_EN` = 0, every lane register loads on every edge.
- R9: When `DATA_W` is below `MIN_GATE_W`, gating is not applied even with `GATE_EN` = 1, and the activity counters match those of an ungated build.
- R10: After reset is released, the pipeline behaves as if code 0 and all-zero data had been applied on the reset edges. The first output is 0, and the second output is lane 0 of the data applied on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; synchronous for the data path, asynchronous for the counters |
| din | input | LANES*DATA_W | Packed lane data, lane k in bits [k*DATA_W +: DATA_W] |
| sel | input | clog2(LANES) | Lane code |
| dout | output | DATA_W | Registered selected lane |
| act_cnt | output | LANES*CNT_W | Packed per-lane bit-flip counters |

## Verification
Suppose the enable decode is off by one stage, or decodes the wrong lane. Then the output stage reads a register that still holds data from an earlier cycle. The error shows on `dout` one edge after the first lane change, and the bench catches it by comparing the output against an arithmetic model and against an ungated twin. An enable that is stuck on loses no data, so it does not show on `dout`. It does show in the activity counters of lanes that were not selected, on the same edge, and a directed pattern with all bits flipping exposes it exactly.

// File: rtl/actgate_pkg.sv
package actgate_pkg;
  localparam int unsigned AG_LANES      = 8;
  localparam int unsigned AG_DATA_W     = 8;
  localparam int unsigned AG_CNT_W      = 16;
  localparam int unsigned AG_MIN_GATE_W = 8;
  localparam int unsigned AG_WARM_EDGES = 3;
endpackage

// File: rtl/actgate_sel_pipe.sv
module actgate_sel_pipe #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned SEL_W  = 3,
  parameter bit          GATING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] pick_o,
  output logic [LANES-1:0] load_en_o
);
  localparam bit HAS_SPARE = ((1 << SEL_W) > LANES);

  logic [SEL_W-1:0] s1_q, s1_d;
  logic [SEL_W-1:0] s2_q, s2_d;

  always_comb begin
    s1_d = sel_i;
    s2_d = s1_q;
  end

  // synchronous reset, explicit value for every register in the branch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign pick_o = s2_q;

  generate
    if (!GATING) begin : g_free
      assign load_en_o = '1;
    end else if (HAS_SPARE) begin : g_gate_spare
      always_comb begin
        for (int k = 0; k < int'(LANES); k++) load_en_o[k] = (s1_q == SEL_W'(k));
        if (s1_q > SEL_W'(LANES - 1)) load_en_o[0] = 1'b1;
      end
    end else begin : g_gate
      always_comb begin
        for (int k = 0; k < int'(LANES); k++) load_en_o[k] = (s1_q == SEL_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/actgate_in_bank.sv
module actgate_in_bank #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] din_i,
  input  logic [LANES-1:0]        load_en_i,
  output logic [LANES*DATA_W-1:0] lane_q_o,
  output logic [LANES*CNT_W-1:0]  act_cnt_o
);
  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    logic [DATA_W-1:0] q, q_next, flips;
    logic [CNT_W-1:0]  cnt_q, cnt_next, delta;
    logic [CNT_W:0]    sum;

    // clock enable written out as a hold mux
    always_comb begin
      q_next = load_en_i[k] ? din_i[k*DATA_W +: DATA_W] : q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
    end

    always_comb begin
      flips = q ^ q_next;
      delta = '0;
      for (int b = 0; b < int'(DATA_W); b++) delta = delta + CNT_W'(flips[b]);
      sum      = {1'b0, cnt_q} + {1'b0, delta};
      cnt_next = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next;
    end

    assign lane_q_o[k*DATA_W +: DATA_W] = q;
    assign act_cnt_o[k*CNT_W +: CNT_W]  = cnt_q;
  end
endmodule

// File: rtl/actgate_out_stage.sv
module actgate_out_stage #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] lanes_i,
  input  logic [SEL_W-1:0]        pick_i,
  output logic [DATA_W-1:0]       dout_o
);
  logic [DATA_W-1:0] chosen, out_q;

  // unmatched codes fall back to lane 0
  always_comb begin
    chosen = lanes_i[DATA_W-1:0];
    for (int k = 1; k < int'(LANES); k++)
      if (pick_i == SEL_W'(k)) chosen = lanes_i[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= chosen;
  end

  assign dout_o = out_q;
endmodule

// File: rtl/actgate_sel8.sv
module actgate_sel8 #(
  parameter int unsigned LANES      = actgate_pkg::AG_LANES,
  parameter int unsigned DATA_W     = actgate_pkg::AG_DATA_W,
  parameter int unsigned CNT_W      = actgate_pkg::AG_CNT_W,
  parameter int unsigned MIN_GATE_W = actgate_pkg::AG_MIN_GATE_W,
  parameter bit          GATE_EN    = 1'b1,
  localparam int unsigned SEL_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] din,
  input  logic [SEL_W-1:0]        sel,
  output logic [DATA_W-1:0]       dout,
  output logic [LANES*CNT_W-1:0]  act_cnt
);
  localparam bit GATING = GATE_EN && (DATA_W >= MIN_GATE_W);

  logic [SEL_W-1:0]        pick_w;
  logic [LANES-1:0]        load_en_w;
  logic [LANES*DATA_W-1:0] lane_q_w;

  actgate_sel_pipe #(.LANES(LANES), .SEL_W(SEL_W), .GATING(GATING)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .pick_o(pick_w), .load_en_o(load_en_w)
  );

  actgate_in_bank #(.LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .din_i(din), .load_en_i(load_en_w),
    .lane_q_o(lane_q_w), .act_cnt_o(act_cnt)
  );

  actgate_out_stage #(.LANES(LANES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .lanes_i(lane_q_w), .pick_i(pick_w), .dout_o(dout)
  );
endmodule

// File: rtl/actgate_sel8_chk.sv
module actgate_sel8_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 3,
  parameter bit          GATING = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*DATA_W-1:0] din,
  input logic [SEL_W-1:0]        sel,
  input logic [DATA_W-1:0]       dout,
  input logic [LANES*CNT_W-1:0]  act_cnt,
  input logic [LANES-1:0]        load_en,
  input logic [LANES*DATA_W-1:0] lane_q
);
  logic [LANES*DATA_W-1:0] din_d1, din_d2;
  logic [SEL_W-1:0]        sel_d1, sel_d2, sel_d3;
  logic [1:0]              warm;
  logic [DATA_W-1:0]       expect_out;

  always_ff @(posedge clk) begin
    din_d1 <= din;    din_d2 <= din_d1;
    sel_d1 <= sel;    sel_d2 <= sel_d1;   sel_d3 <= sel_d2;
    if (!rst_n)              warm <= '0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end

  always_comb begin
    expect_out = din_d2[DATA_W-1:0];
    for (int k = 1; k < int'(LANES); k++)
      if (sel_d3 == SEL_W'(k)) expect_out = din_d2[k*DATA_W +: DATA_W];
  end

  p_reset_out_r1: assert property (@(posedge clk) !rst_n |=> dout == '0);
  p_reset_cnt_r1: assert property (@(posedge clk) !rst_n |=> act_cnt == '0);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> dout == expect_out);

  if (GATING) begin : g_gated
    p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(load_en) == 1);
  end

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane_chk
    p_hold_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en[k] |=> $stable(lane_q[k*DATA_W +: DATA_W]));
    p_quiet_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en[k] |=> $stable(act_cnt[k*CNT_W +: CNT_W]));
    p_cnt_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_cnt[k*CNT_W +: CNT_W] >= $past(act_cnt[k*CNT_W +: CNT_W]));
  end
endmodule

bind actgate_sel8 actgate_sel8_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .GATING(GATING)
) chk_i (
  .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .dout(dout),
  .act_cnt(act_cnt), .load_en(load_en_w), .lane_q(lane_q_w)
);

// File: tb/actgate_sel8_tb_top.sv
module actgate_sel8_tb_top;
  localparam int L  = 8;
  localparam int W  = 8;
  localparam int CW = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [L*W-1:0]  din;
  logic [L*NW-1:0] din_n;
  logic [2:0]      sel;
  logic [W-1:0]    dout_g, dout_u;
  logic [NW-1:0]   dout_ng, dout_nu;
  logic [L*CW-1:0] cnt_g, cnt_u, cnt_ng, cnt_nu;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [L*W-1:0] hd_0, hd_m1;
  logic [2:0]     hs_0, hs_m1, hs_m2;

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < L; k++) din_n[k*NW +: NW] = din[k*W +: NW];
  end

  actgate_sel8 #(.GATE_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .dout(dout_g), .act_cnt(cnt_g));
  actgate_sel8 #(.GATE_EN(1'b0)) ref_i (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .dout(dout_u), .act_cnt(cnt_u));
  actgate_sel8 #(.DATA_W(NW), .GATE_EN(1'b1)) nar_g_i (
    .clk(clk), .rst_n(rst_n), .din(din_n), .sel(sel), .dout(dout_ng), .act_cnt(cnt_ng));
  actgate_sel8 #(.DATA_W(NW), .GATE_EN(1'b0)) nar_u_i (
    .clk(clk), .rst_n(rst_n), .din(din_n), .sel(sel), .dout(dout_nu), .act_cnt(cnt_nu));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane_of(input logic [L*W-1:0] v, input logic [2:0] c);
    return v[c*W +: W];
  endfunction

  function automatic logic [CW-1:0] cnt_of(input logic [L*CW-1:0] v, input int k);
    return v[k*CW +: CW];
  endfunction

  // one cycle: drive at negedge, let an edge pass, check at the next negedge
  task automatic cyc(input logic [2:0] s, input logic [L*W-1:0] d);
    logic [W-1:0] exp;
    sel = s;
    din = d;
    @(posedge clk);
    hs_m2 = hs_m1; hs_m1 = hs_0; hs_0 = s;
    hd_m1 = hd_0;  hd_0 = d;
    @(negedge clk);
    exp = lane_of(hd_m1, hs_m2);
    check(dout_g == exp, "R2/R3/R10 output", 32'(dout_g), 32'(exp));
    check(dout_g == dout_u, "R5 gated vs ungated", 32'(dout_g), 32'(dout_u));
    check(dout_ng == exp[NW-1:0], "R9 narrow output", 32'(dout_ng), 32'(exp[NW-1:0]));
  endtask

  initial begin
    rst_n = 1'b0;
    sel   = '0;
    din   = '0;
    hd_0 = '0; hd_m1 = '0; hs_0 = '0; hs_m1 = '0; hs_m2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(dout_g == '0, "R1 dout in reset", 32'(dout_g), 0);
    check(cnt_g == '0, "R1 counters in reset", 32'(cnt_g[31:0]), 0);
    rst_n = 1'b1;

    // directed: lane code 3 held, all bits of every lane flip twice
    cyc(3'd3, '0);
    cyc(3'd3, '1);
    cyc(3'd3, '0);
    for (int k = 0; k < L; k++) begin
      check(cnt_of(cnt_g, k) == ((k == 3) ? CW'(16) : CW'(0)), "R4/R6 gated lane activity",
            32'(cnt_of(cnt_g, k)), (k == 3) ? 16 : 0);
      check(cnt_of(cnt_u, k) == CW'(16), "R8 ungated lane activity", 32'(cnt_of(cnt_u, k)), 16);
    end

    // sweep of every ordered pair of lane codes with lane-tagged data
    for (int a = 0; a < L; a++) begin
      for (int b = 0; b < L; b++) begin
        logic [L*W-1:0] d;
        for (int k = 0; k < L; k++) d[k*W +: W] = W'((a * 37 + b * 11 + k * 29) ^ (k << 5));
        cyc(3'(a), d);
        for (int k = 0; k < L; k++) d[k*W +: W] = ~d[k*W +: W] ^ W'(k);
        cyc(3'(b), d);
      end
    end

    // random run
    for (int n = 0; n < 1000; n++) begin
      logic [L*W-1:0] d;
      for (int k = 0; k < L; k++) d[k*W +: W] = W'($urandom);
      cyc(3'($urandom), d);
    end

    begin
      int tg, tu;
      tg = 0; tu = 0;
      for (int k = 0; k < L; k++) begin
        tg += int'(cnt_of(cnt_g, k));
        tu += int'(cnt_of(cnt_u, k));
        check(cnt_of(cnt_ng, k) == cnt_of(cnt_nu, k), "R9 narrow activity equals ungated",
              32'(cnt_of(cnt_ng, k)), 32'(cnt_of(cnt_nu, k)));
      end
      check(tg < tu, "R7 gated activity below ungated", tg, tu);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule